// File: doc/BRIEF.md
# Triggered DMA Channel Sequencer

A single DMA channel that copies 16-bit words from a source address to a destination address. The work is organised as bursts of one or more words, and a transfer is made of one or more bursts. Each burst is started by a trigger. The trigger comes from a peripheral event on `trig_i` or from a software force strobe. After each word, and again after each burst, the source and destination addresses move by their own signed step values. Each side can also wrap back to a moving base address after a programmed number of bursts.

Software programs the channel through a small write-only register port. This sets the sizes, the steps, the wrap settings, the shadow addresses and the mode bits, and it issues the command strobes. Three mode bits shape the behaviour:
- One-shot mode lets a single trigger run a whole transfer.
- Continuous mode keeps the channel armed after a transfer and reloads it from the shadow registers.
- A third bit chooses whether the channel interrupt pulses when a transfer starts or when it ends.

Each word needs two cycles on the memory port: a read cycle, then a write cycle.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `run_o`, `int_o`, `err_o` and `mem_req_o` are all 0.
- R2: The burst size register (index 2) holds words-per-burst minus one. Each word is a read cycle (`mem_req_o`=1, `mem_we_o`=0) at the source address, followed by a write cycle at the destination address carrying the data that was read.
- R3: The transfer size register (index 3) holds bursts-per-transfer minus one. With continuous mode off, `run_o` goes low after the last word of the last burst. A run strobe (control register index 1, bit 0) starts an idle channel.
- R4: With one-shot off (mode bit 1 = 0), each burst waits for its own trigger, and one trigger produces exactly one burst.
- R5: With one-shot on, a single trigger runs every burst of the transfer back to back.
- R6: With continuous mode on (mode bit 2 = 1), the channel stays running after a transfer ends. It reloads its addresses from the shadow registers as they stand at that moment.
- R7: `int_o` pulses for one cycle. With mode bit 3 = 1 it pulses at the end of each transfer. With mode bit 3 = 0 it pulses when a transfer is started.
- R8: Each side has a signed within-burst step (source index 4, destination index 10) and a signed between-burst step (index 5 / 11). A step of 0 keeps the address fixed.
- R9: Each side has a wrap size (index 6 / 12) and a wrap step (index 7 / 13). A wrap size of all ones disables wrapping. A wrap size of W wraps at the end of every (W+1)-th burst: the base address advances by the wrap step and the address is set to the new base. Base and current shadow addresses sit at index 8 / 14 and 9 / 15.
- R10: A force strobe (control bit 1) acts as a trigger even when peripheral triggers are disabled. A `trig_i` edge is ignored when mode bit 0 = 0.
- R11: A trigger-clear strobe (control bit 2) discards a latched trigger that has not been serviced.
- R12: A trigger arriving while an earlier one is still latched sets `err_o`. An error-clear strobe (control bit 3) clears it.
- R13: `trig_i` is latched on its rising edge, so a level held high counts as one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | AW | Register write data |
| trig_i | input | 1 | Peripheral trigger, rising-edge sensitive |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the same cycle as the read request |
| run_o | output | 1 | Channel armed or busy |
| int_o | output | 1 | One-cycle channel interrupt pulse |
| err_o | output | 1 | Trigger overflow flag |

## Verification
Timing after each stimulus:
- A trigger edge is latched on the next clock edge. The first read follows one cycle later, and the matching write comes one cycle after that. A burst of N words therefore finishes about 2N+2 cycles after the trigger.
- The start interrupt appears in the cycle right after the run strobe's register write.
- The end interrupt and the drop of `run_o` appear in the cycle after the last write.

How the checks keep to that timing:
- Expected writes go into a scoreboard queue before the stimulus is applied. A monitor compares every write cycle at the falling edge.
- Level and count checks (running state, interrupt count, error flag, number of writes) are made only after an idle gap of 20 or more cycles, well past every result's due cycle.
- Scenarios where a trigger must not start a burst are confirmed by an unchanged write count and a still-high `run_o`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} seq_state_e;

  localparam logic [3:0] REG_MODE  = 4'd0;
  localparam logic [3:0] REG_CTRL  = 4'd1;
  localparam logic [3:0] REG_BSIZE = 4'd2;
  localparam logic [3:0] REG_XSIZE = 4'd3;
  localparam logic [3:0] SRC_BASE  = 4'd4;
  localparam logic [3:0] DST_BASE  = 4'd10;

  localparam int MODE_TRIG_EN = 0;
  localparam int MODE_ONESHOT = 1;
  localparam int MODE_CONT    = 2;
  localparam int MODE_INT_END = 3;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_FORCE   = 1;
  localparam int CTRL_TRG_CLR = 2;
  localparam int CTRL_ERR_CLR = 3;
endpackage

// File: rtl/dma_trig_latch.sv
module dma_trig_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic en_i,
  input  logic force_i,
  input  logic clr_i,
  input  logic err_clr_i,
  input  logic consume_i,
  output logic pend_o,
  output logic err_o
);
  logic trig_q, pend_q, err_q, ev;

  assign ev = (en_i & trig_i & ~trig_q) | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (clr_i)          pend_q <= 1'b0;
      else if (ev)        pend_q <= 1'b1;
      else if (consume_i) pend_q <= 1'b0;
      // overflow: new event on top of an unserviced one
      if (ev && pend_q && !consume_i && !clr_i) err_q <= 1'b1;
      else if (err_clr_i)                       err_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;

  a_r12_ovf_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && pend_q && !consume_i && !clr_i) |=> err_o);
  a_r11_clr_discards: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_o);
  a_r13_level_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && trig_i && trig_q && !force_i) |=> !pend_o);
endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side #(
  parameter int         AW   = 16,
  parameter logic [3:0] BASE = 4'd4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [3:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          load_i,
  input  logic          word_adv_i,
  input  logic          burst_adv_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] bstep_q, xstep_q, wsize_q, wstep_q, beg_sh_q, cur_sh_q;
  logic [AW-1:0] beg_q, addr_q, wcnt_q, beg_next;
  logic          wrap_en, do_wrap;

  assign wrap_en  = ~&wsize_q;
  assign do_wrap  = wrap_en && (wcnt_q == '0);
  assign beg_next = beg_q + wstep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bstep_q <= '0; xstep_q <= '0; wsize_q <= '1; wstep_q <= '0;
      beg_sh_q <= '0; cur_sh_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == BASE)        bstep_q  <= cfg_wdata_i;
      if (cfg_addr_i == BASE + 4'd1) xstep_q  <= cfg_wdata_i;
      if (cfg_addr_i == BASE + 4'd2) wsize_q  <= cfg_wdata_i;
      if (cfg_addr_i == BASE + 4'd3) wstep_q  <= cfg_wdata_i;
      if (cfg_addr_i == BASE + 4'd4) beg_sh_q <= cfg_wdata_i;
      if (cfg_addr_i == BASE + 4'd5) cur_sh_q <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beg_q <= '0; addr_q <= '0; wcnt_q <= '0;
    end else if (load_i) begin
      beg_q  <= beg_sh_q;
      addr_q <= cur_sh_q;
      wcnt_q <= wsize_q;
    end else if (word_adv_i) begin
      addr_q <= addr_q + bstep_q;
    end else if (burst_adv_i) begin
      if (do_wrap) begin
        beg_q  <= beg_next;
        addr_q <= beg_next;
        wcnt_q <= wsize_q;
      end else begin
        addr_q <= addr_q + xstep_q;
        wcnt_q <= wcnt_q - 1'b1;
      end
    end
  end

  assign addr_o = addr_q;

  a_r9_wrap_to_beg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_adv_i && !load_i && !word_adv_i && do_wrap) |=> (addr_q == beg_q));
  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !word_adv_i && !burst_adv_i) |=> $stable(addr_q));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [3:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          trig_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          run_o,
  output logic          int_o,
  output logic          err_o
);
  localparam int NSIDE = 2;

  seq_state_e    state_q;
  logic [3:0]    mode_q;
  logic [AW-1:0] bsize_q, xsize_q, wcnt_q, xcnt_q;
  logic [DW-1:0] data_q;
  logic          int_q, pend;
  logic          ctrl_we, run_stb, force_stb, clr_stb, eclr_stb;
  logic          word_last, xfer_last, at_end, load, word_adv, burst_adv, consume;
  logic [AW-1:0] side_addr [NSIDE];

  assign ctrl_we   = cfg_we_i && (cfg_addr_i == REG_CTRL);
  assign run_stb   = ctrl_we && cfg_wdata_i[CTRL_RUN];
  assign force_stb = ctrl_we && cfg_wdata_i[CTRL_FORCE];
  assign clr_stb   = ctrl_we && cfg_wdata_i[CTRL_TRG_CLR];
  assign eclr_stb  = ctrl_we && cfg_wdata_i[CTRL_ERR_CLR];

  assign word_last = (wcnt_q == '0);
  assign xfer_last = (xcnt_q == '0);
  assign at_end    = (state_q == ST_WR) && word_last && xfer_last;
  assign load      = ((state_q == ST_IDLE) && run_stb) || (at_end && mode_q[MODE_CONT]);
  assign word_adv  = (state_q == ST_WR) && !word_last;
  assign burst_adv = (state_q == ST_WR) && word_last;
  assign consume   = (state_q == ST_WAIT) && pend;

  dma_trig_latch u_trig (
    .clk_i, .rst_ni, .trig_i,
    .en_i(mode_q[MODE_TRIG_EN]), .force_i(force_stb), .clr_i(clr_stb),
    .err_clr_i(eclr_stb), .consume_i(consume), .pend_o(pend), .err_o
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [3:0] SBASE = (s == 0) ? SRC_BASE : DST_BASE;
    dma_addr_side #(.AW(AW), .BASE(SBASE)) u_side (
      .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
      .load_i(load), .word_adv_i(word_adv), .burst_adv_i(burst_adv),
      .addr_o(side_addr[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; bsize_q <= '0; xsize_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == REG_MODE)  mode_q  <= cfg_wdata_i[3:0];
      if (cfg_addr_i == REG_BSIZE) bsize_q <= cfg_wdata_i;
      if (cfg_addr_i == REG_XSIZE) xsize_q <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      xcnt_q  <= '0;
      data_q  <= '0;
      int_q   <= 1'b0;
    end else begin
      int_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (run_stb) begin
          state_q <= ST_WAIT;
          xcnt_q  <= xsize_q;
          int_q   <= !mode_q[MODE_INT_END];
        end
        ST_WAIT: if (pend) begin
          state_q <= ST_RD;
          wcnt_q  <= bsize_q;
        end
        ST_RD: begin
          data_q  <= mem_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: begin
          if (!word_last) begin
            wcnt_q  <= wcnt_q - 1'b1;
            state_q <= ST_RD;
          end else if (!xfer_last) begin
            xcnt_q  <= xcnt_q - 1'b1;
            wcnt_q  <= bsize_q;
            state_q <= mode_q[MODE_ONESHOT] ? ST_RD : ST_WAIT;
          end else if (mode_q[MODE_CONT]) begin
            xcnt_q  <= xsize_q;
            state_q <= ST_WAIT;
            int_q   <= 1'b1;  // end of this one or start of the next
          end else begin
            state_q <= ST_IDLE;
            int_q   <= mode_q[MODE_INT_END];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o       = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? side_addr[1] : side_addr[0];
  assign mem_wdata_o = data_q;
  assign int_o       = int_q;

  a_r2_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));
  a_r4_burst_needs_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !pend) |=> (state_q != ST_RD));
  a_r3_stop_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && !mode_q[MODE_CONT]) |=> !run_o);
  a_r5_oneshot_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_adv && !xfer_last && mode_q[MODE_ONESHOT]) |=> (mem_req_o && !mem_we_o));
  a_r6_cont_stays_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && mode_q[MODE_CONT]) |=> run_o);
endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          trig = 1'b0;
  logic          mem_req, mem_we, run, intr, err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, int_cnt = 0;
  logic [31:0] exp_q [$];

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] src_val(input logic [AW-1:0] a);
    return a ^ 16'h5A3C;
  endfunction
  assign mem_rdata = src_val(mem_addr);

  dma_chan_seq #(.AW(AW), .DW(DW)) u_dma_chan_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trig_i(trig), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .run_o(run), .int_o(intr), .err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every write cycle is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (intr) int_cnt++;
      if (mem_req && mem_we) begin
        wr_cnt++;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8 unexpected write act=%h exp=none", {mem_addr, mem_wdata});
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            n_bad++;
            $display("FAIL R2 R8 write act=%h exp=%h", {mem_addr, mem_wdata}, e);
          end
        end
      end
    end
  end

  task automatic push(input logic [AW-1:0] s, input logic [AW-1:0] d);
    exp_q.push_back({d, src_val(s)});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic side(input logic [3:0] b, input logic [AW-1:0] bs, input logic [AW-1:0] xs,
                      input logic [AW-1:0] ws, input logic [AW-1:0] wst, input logic [AW-1:0] a);
    cfg(b, bs); cfg(b + 4'd1, xs); cfg(b + 4'd2, ws);
    cfg(b + 4'd3, wst); cfg(b + 4'd4, a); cfg(b + 4'd5, a);
  endtask

  // mode bits: 0 trig_en, 1 oneshot, 2 cont, 3 int_end; ctrl: 0 run, 1 force, 2 trg_clr, 3 err_clr
  initial begin
    int wb, ib;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 run", run, 0);
    check("R1 int", intr, 0);
    check("R1 err", err, 0);
    check("R1 req", mem_req, 0);

    // R4 / R3 / R7: 2-word bursts, 3 bursts, dst steps +1 then -1
    cfg(4'd2, 16'd1); cfg(4'd3, 16'd2);
    side(4'd4, 16'd1, 16'd1, 16'hFFFF, 16'd0, 16'h0100);
    side(4'd10, 16'd1, 16'hFFFF, 16'hFFFF, 16'd0, 16'h0200);
    cfg(4'd0, 16'b1001);
    ib = int_cnt;
    cfg(4'd1, 16'b0001);
    idle(3);
    check("R3 run after start", run, 1);
    check("R7 no start int", int_cnt - ib, 0);
    wb = wr_cnt;
    push(16'h0100, 16'h0200); push(16'h0101, 16'h0201);
    pulse(); idle(20);
    check("R4 one burst per trigger", wr_cnt - wb, 2);
    check("R4 still running", run, 1);
    push(16'h0102, 16'h0200); push(16'h0103, 16'h0201);
    push(16'h0104, 16'h0200); push(16'h0105, 16'h0201);
    pulse(); idle(20); pulse(); idle(20);
    check("R3 stopped", run, 0);
    check("R7 end int", int_cnt - ib, 1);
    check("R2 queue drained", exp_q.size(), 0);

    // R13: held trigger counts once
    cfg(4'd2, 16'd0); cfg(4'd3, 16'd1);
    side(4'd10, 16'd0, 16'd0, 16'hFFFF, 16'd0, 16'h0200);
    cfg(4'd1, 16'b0001);
    wb = wr_cnt;
    push(16'h0100, 16'h0200);
    @(negedge clk); trig = 1'b1;
    idle(20);
    check("R13 level counts once", wr_cnt - wb, 1);
    trig = 1'b0;
    push(16'h0101, 16'h0200);
    pulse(); idle(20);
    check("R13 second edge", wr_cnt - wb, 2);
    check("R3 stopped after 2", run, 0);

    // R5 one-shot, R8 fixed destination
    cfg(4'd2, 16'd1); cfg(4'd3, 16'd2);
    side(4'd10, 16'd0, 16'd0, 16'hFFFF, 16'd0, 16'h0210);
    cfg(4'd0, 16'b1011);
    for (int i = 0; i < 6; i++) push(16'h0100 + 16'(i), 16'h0210);
    cfg(4'd1, 16'b0001);
    wb = wr_cnt;
    pulse(); idle(40);
    check("R5 whole transfer one trigger", wr_cnt - wb, 6);
    check("R5 done", run, 0);
    check("R8 queue drained", exp_q.size(), 0);

    // R9 wrap after 2 bursts, step 0x10; R7 start interrupt
    cfg(4'd2, 16'd0); cfg(4'd3, 16'd4);
    side(4'd4, 16'd0, 16'd1, 16'd1, 16'h0010, 16'h0300);
    side(4'd10, 16'd0, 16'd0, 16'hFFFF, 16'd0, 16'h0400);
    cfg(4'd0, 16'b0011);
    ib = int_cnt;
    cfg(4'd1, 16'b0001);
    idle(2);
    check("R7 start int", int_cnt - ib, 1);
    push(16'h0300, 16'h0400); push(16'h0301, 16'h0400); push(16'h0310, 16'h0400);
    push(16'h0311, 16'h0400); push(16'h0320, 16'h0400);
    pulse(); idle(40);
    check("R9 queue drained", exp_q.size(), 0);
    check("R7 no end int", int_cnt - ib, 1);
    check("R9 done", run, 0);

    // R10 / R6: force trigger, continuous reload from shadow
    cfg(4'd3, 16'd1);
    side(4'd4, 16'd0, 16'd1, 16'hFFFF, 16'd0, 16'h0500);
    cfg(4'd0, 16'b1110);
    cfg(4'd1, 16'b0001);
    wb = wr_cnt;
    pulse(); idle(20);
    check("R10 trig ignored when disabled", wr_cnt - wb, 0);
    cfg(4'd8, 16'h0600); cfg(4'd9, 16'h0600);
    push(16'h0500, 16'h0400); push(16'h0501, 16'h0400);
    cfg(4'd1, 16'b0010); idle(20);
    check("R10 force moved burst", wr_cnt - wb, 2);
    check("R6 still running", run, 1);
    cfg(4'd0, 16'b1010);
    push(16'h0600, 16'h0400); push(16'h0601, 16'h0400);
    cfg(4'd1, 16'b0010); idle(20);
    check("R6 reload from shadow", exp_q.size(), 0);
    check("R6 stops when cleared", run, 0);

    // R11 trigger clear
    cfg(4'd3, 16'd0);
    cfg(4'd8, 16'h0700); cfg(4'd9, 16'h0700);
    cfg(4'd0, 16'b1001);
    pulse(); cfg(4'd1, 16'b0100);
    cfg(4'd1, 16'b0001);
    wb = wr_cnt;
    idle(20);
    check("R11 cleared trigger ignored", wr_cnt - wb, 0);
    check("R11 waiting", run, 1);
    push(16'h0700, 16'h0400);
    pulse(); idle(20);
    check("R11 later trigger served", exp_q.size(), 0);
    check("R11 done", run, 0);

    // R12 overflow
    cfg(4'd0, 16'b0001);
    pulse(); idle(3);
    check("R12 single trigger no err", err, 0);
    pulse(); idle(3);
    check("R12 overflow sets err", err, 1);
    cfg(4'd1, 16'b1000); idle(2);
    check("R12 err clear", err, 0);
    cfg(4'd1, 16'b0100); idle(2);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule